// File: doc/BRIEF.md
# Programmable Interval Timer with Deferred Reload

This block is an 8-bit interval timer. Software reaches it through a small register bus. A 16-bit divider advances on every clock. The control register switches the timer on and picks one of four divider bits. That bit is ANDed with the enable, and a falling edge on the result advances the 8-bit counter.

Because the counter reacts to a falling edge of the gated signal, some register writes produce extra counts: turning the timer off, switching to a tap that is low, or clearing the divider while the gated signal is high. When the counter wraps past FFh through its own increment, it holds 00h for one machine cycle of four clocks. On the fourth clock it loads the modulo value and emits a single-clock interrupt pulse, which an external flag register latches.

Register addresses are: 0 for the divider (the read returns bits 15:8, and any write clears it), 1 for the counter, 2 for the modulo and 3 for the control.

Top module: `ptimer_top`

## Requirements
- R1: After reset, the counter, modulo and control registers read 00h, the divider reads 00h, and the interrupt output is low.
- R2: The divider advances by one on every clock. Address 0 returns its bits 15:8. A write to address 0, whatever the data, clears all 16 bits.
- R3: Control bit 2 is the enable and bits 1:0 select the tap. Select 00 uses divider bit 9, 01 uses bit 3, 10 uses bit 5 and 11 uses bit 7. A read of address 3 returns the three control bits with zeros above them.
- R4: The counter advances by one on the clock that follows the edge where (enable AND tap) goes from 1 to 0. For a tap at bit b, the first increment after a divider clear lands 2^(b+1)+1 clocks after the clearing edge.
- R5: A control write that drops the gated signal from 1 to 0 produces one increment. This covers clearing the enable and also switching to a tap that is low. Alternating control writes of 05h and 00h on successive clocks, starting one clock after a divider clear, give exactly four increments over sixteen writes.
- R6: Clearing the divider while the gated signal is 1 produces one increment on the following clock.
- R7: When the counter's own increment wraps it from FFh, it reads 00h for four clocks. On the fourth clock after the wrapping edge it loads the modulo value.
- R8: The interrupt output is high for exactly one clock. That clock is the one in which the modulo reload becomes visible.
- R9: A software write never starts the reload or the interrupt. This includes writing FFh and then 00h to the counter.
- R10: A counter write on any of the four clocks after a wrap cancels the pending reload and interrupt, and the written value stays. On the same clock, a counter write wins over an increment.
- R11: A modulo write on the reload clock also puts the newly written value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 2 | Register address: 0 divider, 1 counter, 2 modulo, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Single-clock timer interrupt pulse |

## Verification
Two events can fall on the same clock: the deferred reload with its interrupt, and a software write to the counter or the modulo register. The bench lets the counter wrap from FFh through a real tap edge and then counts clocks from the divider clear. It places a counter write inside the four-clock window and judges that neither the reload nor the pulse follows. It also places a modulo write exactly on the reload clock and requires that the counter shows the fresh value while the pulse is high.

// File: rtl/ptimer_pkg.sv
// Shared constants and register addresses for the interval timer.
// Assumes a four-clock machine cycle and a 16-bit divider.
package ptimer_pkg;
    localparam int DIV_W    = 16;
    localparam int DATA_W   = 8;
    localparam int CTL_W    = 3;
    localparam int CYC_CLKS = 4;
    localparam int N_TAPS   = 4;
    localparam int TAP_POS [N_TAPS] = '{9, 3, 5, 7};

    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_MOD = 2'd2,
        REG_CTL = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ptimer_divider.sv
// Free-running divider. It advances every clock, clears on request,
// and exposes its upper byte and the selectable tap bits.
// Assumes every tap position lies below DIV_W.
module ptimer_divider #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int N_TAPS = 4,
    parameter int TAP_POS [N_TAPS] = '{9, 3, 5, 7}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [DATA_W-1:0] hi_byte,
    output logic [N_TAPS-1:0] taps
);
    logic [DIV_W-1:0] div_q;

    // Advance every clock; a clear request wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    assign hi_byte = div_q[DIV_W-1 -: DATA_W];

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        assign taps[i] = div_q[TAP_POS[i]];
    end
endmodule

// File: rtl/ptimer_tap_edge.sv
// Gates the selected tap with the enable and flags its falling edge.
// The tick is high during the clock after the gated signal dropped.
module ptimer_tap_edge #(
    parameter int N_TAPS = 4,
    localparam int SEL_W = $clog2(N_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] taps,
    input  logic              enable,
    input  logic [SEL_W-1:0]  sel,
    output logic              tick
);
    logic gated;
    logic gated_q;

    assign gated = enable & taps[sel];

    // Remember the previous gated level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gated_q <= 1'b0;
        else        gated_q <= gated;
    end

    assign tick = gated_q & ~gated;
endmodule

// File: rtl/ptimer_counter.sv
// Timer counter with modulo register, deferred reload and interrupt pulse.
// A wrap from all-ones by a tick arms a CYC_CLKS-clock window. At its end
// the modulo value is loaded and irq pulses. A counter write cancels it.
module ptimer_counter #(
    parameter int DATA_W   = 8,
    parameter int CYC_CLKS = 4,
    localparam int DLY_W   = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic              mod_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] modulo_q,
    output logic              pending_q,
    output logic              irq_q
);
    logic [DLY_W-1:0]  dly_q;
    logic              dly_last;
    logic [DATA_W-1:0] reload_val;

    assign dly_last   = (dly_q == DLY_W'(CYC_CLKS - 1));
    assign reload_val = mod_wr ? wdata : modulo_q;

    // Modulo register: plain software storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      modulo_q <= '0;
        else if (mod_wr) modulo_q <= wdata;
    end

    // Counter, pending flag and interrupt: write > reload > tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            pending_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cnt_wr) begin
                count_q   <= wdata;
                pending_q <= 1'b0;
            end else if (pending_q && dly_last) begin
                count_q   <= reload_val;
                pending_q <= 1'b0;
                irq_q     <= 1'b1;
            end else if (tick) begin
                count_q <= count_q + 1'b1;
                if (&count_q) pending_q <= 1'b1;
            end
        end
    end

    // Window timer: restarts on a wrap, advances while pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dly_q <= '0;
        else if (!pending_q)             dly_q <= '0;
        else if (!dly_last)              dly_q <= dly_q + 1'b1;
    end
endmodule

// File: rtl/ptimer_top.sv
// Interval timer top: register decode, control register and read mux.
// Assumes one-clock write strobes and a combinational read path.
module ptimer_top
    import ptimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int SEL_W = $clog2(N_TAPS);

    logic              wr_div, wr_cnt, wr_mod, wr_ctl;
    logic [CTL_W-1:0]  ctl_q;
    logic [DATA_W-1:0] div_hi;
    logic [N_TAPS-1:0] taps;
    logic              tick;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] modulo_q;
    logic              ovf_pending;

    assign wr_div = bus_wr && (bus_addr == REG_DIV);
    assign wr_cnt = bus_wr && (bus_addr == REG_CNT);
    assign wr_mod = bus_wr && (bus_addr == REG_MOD);
    assign wr_ctl = bus_wr && (bus_addr == REG_CTL);

    // Control register: enable in the top bit, tap select below.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
    end

    ptimer_divider #(
        .DIV_W(DIV_W), .DATA_W(DATA_W), .N_TAPS(N_TAPS), .TAP_POS(TAP_POS)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .clr(wr_div),
        .hi_byte(div_hi), .taps(taps)
    );

    ptimer_tap_edge #(.N_TAPS(N_TAPS)) u_edge (
        .clk(clk), .rst_n(rst_n), .taps(taps),
        .enable(ctl_q[CTL_W-1]), .sel(ctl_q[SEL_W-1:0]), .tick(tick)
    );

    ptimer_counter #(.DATA_W(DATA_W), .CYC_CLKS(CYC_CLKS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(wr_cnt), .mod_wr(wr_mod), .wdata(bus_wdata),
        .count_q(count_q), .modulo_q(modulo_q),
        .pending_q(ovf_pending), .irq_q(irq_o)
    );

    // Read mux over the four registers.
    always_comb begin
        unique case (bus_addr)
            REG_DIV: bus_rdata = div_hi;
            REG_CNT: bus_rdata = count_q;
            REG_MOD: bus_rdata = modulo_q;
            default: bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
        endcase
    end
endmodule

// File: rtl/ptimer_checker.sv
// Temporal checks on the interval timer, attached to the top by bind.
module ptimer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       irq_o,
    input logic       pending,
    input logic [7:0] count,
    input logic [7:0] div_hi
);
    import ptimer_pkg::*;

    AST_IRQ_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8

    AST_IRQ_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pending)); // R9

    AST_WRAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (count == 8'h00)); // R7

    AST_CNT_WR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_CNT) |=> (!irq_o && !pending)); // R10

    AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIV) |=> (div_hi == 8'h00)); // R2
endmodule

bind ptimer_top ptimer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .irq_o(irq_o), .pending(ovf_pending), .count(count_q), .div_hi(div_hi)
);

// File: tb/ptimer_top_test.sv
`timescale 1ns/1ps
// Self-checking bench for the interval timer: a vector table for rapid
// enable toggling, then directed tests for timing and corner cases.
module ptimer_top_test;
    localparam logic [1:0] A_DIV = 2'd0, A_CNT = 2'd1, A_MOD = 2'd2, A_CTL = 2'd3;
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IDLE = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{K_WR, A_CNT, 8'h10}, '{K_WR, A_DIV, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_WR, A_CTL, 8'h05}, '{K_WR, A_CTL, 8'h00},
        '{K_IDLE, A_CNT, 8'h00}, '{K_RD, A_CNT, 8'h14},
        '{K_RD, A_CTL, 8'h00}, '{K_WR, A_CTL, 8'h07},
        '{K_RD, A_CTL, 8'h07}, '{K_WR, A_CTL, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptimer_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Write lands on the next rising edge; returns at the following negedge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Leaves divider cleared at T0 and control written at T0+1; returns after T0+1.
    task automatic arm(input logic [7:0] cnt, input logic [7:0] md, input logic [7:0] ctl);
        wr(A_CTL, 8'h00);
        wr(A_CNT, cnt);
        wr(A_MOD, md);
        wr(A_DIV, 8'h00);
        wr(A_CTL, ctl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int tapb [4] = '{9, 3, 5, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CNT, v); chk("R1 counter", v, 8'h00);
        rd(A_MOD, v); chk("R1 modulo", v, 8'h00);
        rd(A_CTL, v); chk("R1 control", v, 8'h00);
        rd(A_DIV, v); chk("R1 divider", v, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);

        // R5 / R3: table walk, rapid enable toggling gives four ticks
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                K_WR: wr(VECS[i].addr, VECS[i].data);
                K_RD: begin
                    rd(VECS[i].addr, v);
                    chk("R5/R3 table", v, VECS[i].data);
                    @(negedge clk);
                end
                default: @(negedge clk);
            endcase
        end

        // R2: divider clears and counts each clock
        wr(A_DIV, 8'hAA);
        rd(A_DIV, v); chk("R2 cleared", v, 8'h00);
        repeat (300) @(negedge clk);
        rd(A_DIV, v); chk("R2 upper byte after 300", v, 8'h01);

        // R3 / R4: each tap's first falling edge after a clear
        for (int s = 0; s < 4; s++) begin
            int fall;
            fall = (1 << (tapb[s] + 1)) + 1;
            arm(8'h40, 8'h00, 8'h04 | s[7:0]);
            for (int k = 2; k <= fall; k++) begin
                @(negedge clk);
                if (k == fall - 1) begin rd(A_CNT, v); chk("R4 before tap edge", v, 8'h40); end
                if (k == fall)     begin rd(A_CNT, v); chk("R3 tap edge increment", v, 8'h41); end
            end
        end

        // R7 / R8: natural wrap, four clocks of zero, then reload with pulse
        arm(8'hFF, 8'hA5, 8'h05);
        for (int k = 2; k <= 24; k++) begin
            @(negedge clk);
            rd(A_CNT, v);
            chk("R7 count window", v, (k < 17) ? 8'hFF : (k < 21) ? 8'h00 : 8'hA5);
            chk("R8 irq timing", {7'd0, irq_o}, (k == 21) ? 8'h01 : 8'h00);
        end

        // R10: counter write inside the window cancels reload and pulse
        arm(8'hFF, 8'hA5, 8'h05);
        for (int k = 2; k <= 18; k++) @(negedge clk);
        wr(A_CNT, 8'h33);
        for (int k = 19; k <= 26; k++) begin
            rd(A_CNT, v); chk("R10 write kept", v, 8'h33);
            chk("R10 no irq", {7'd0, irq_o}, 8'h00);
            @(negedge clk);
        end

        // R11: modulo write on the reload clock reaches the counter
        arm(8'hFF, 8'hA5, 8'h05);
        for (int k = 2; k <= 20; k++) @(negedge clk);
        wr(A_MOD, 8'h5A);
        rd(A_CNT, v); chk("R11 fresh modulo loaded", v, 8'h5A);
        chk("R11 irq with reload", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        chk("R8 pulse ends", {7'd0, irq_o}, 8'h00);

        // R6: divider clear while gated tap is high
        arm(8'h40, 8'h00, 8'h05);
        for (int k = 2; k <= 10; k++) @(negedge clk);
        wr(A_DIV, 8'h00);
        rd(A_CNT, v); chk("R6 not yet", v, 8'h40);
        @(negedge clk);
        rd(A_CNT, v); chk("R6 divider clear tick", v, 8'h41);

        // R5: switching to a low tap while enabled
        arm(8'h20, 8'h00, 8'h05);
        for (int k = 2; k <= 10; k++) @(negedge clk);
        wr(A_CTL, 8'h04);
        @(negedge clk);
        rd(A_CNT, v); chk("R5 tap switch tick", v, 8'h21);
        repeat (8) @(negedge clk);
        rd(A_CNT, v); chk("R5 single tick only", v, 8'h21);

        // R9: software FF then 00 never raises the pulse
        wr(A_CTL, 8'h00);
        wr(A_CNT, 8'hFF);
        wr(A_CNT, 8'h00);
        for (int k = 0; k < 8; k++) begin
            chk("R9 no irq from writes", {7'd0, irq_o}, 8'h00);
            @(negedge clk);
        end
        rd(A_CNT, v); chk("R9 count unchanged", v, 8'h00);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule